// File: doc/BRIEF.md
# Snoop Bus Arbitration Sequencer

This block decides, clock by clock, which bus cycle a processor bus interface may start. The cycle is a processor read or write, or a write-back of a modified line found by an external snoop. Three external mechanisms can take the bus away. An address-hold input floats the address lines but lets the current transfer finish. A back-off input stops everything on the next clock, and the interrupted cycle is later restarted. A hold request hands the whole bus to another master once the processor reaches a point where it may give the bus up.

Processor cycles arrive on a request interface with an address and a kind: single-transfer (made of several address-strobe/ready transfers), burst (one address strobe and several burst-ready beats), or uncached code fetch. Snoop write-backs arrive as pulses with a line address and wait in a small first-in first-out queue. A queued write-back always takes the next free address slot, ahead of the remainder of a split or backed-off processor cycle. The block drives the address strobe, a flag saying the strobe belongs to a write-back, the address, the hold acknowledge, an address-float enable, and one-clock strobes for request acceptance and cycle completion.

Top module: `snoop_bus_seq`

## Requirements
- R1: The address-float output is high in every clock where the address-hold input is high, from the clock after the back-off input is sampled high until the back-off ends, and in every clock where hold acknowledge is high.
- R2: While the address-hold input is high, an address strobe is issued only for a snoop write-back. A processor cycle neither starts nor resumes until address-hold has been sampled low.
- R3: A burst cycle already in its data phase when address-hold rises runs all of its BL beats. A queued write-back gets its address strobe two clocks after the last beat.
- R4: A single-transfer or code-fetch cycle under address-hold finishes the transfer in progress and is split there. Every queued write-back, in arrival order, runs before the next transfer of that cycle.
- R5: In the clock after the back-off input is sampled high, no address strobe is driven and no ready or burst-ready is taken.
- R6: When back-off is released, queued write-backs run first. The backed-off cycle is then restarted with a new address strobe carrying its original address and kind, and the interrupted transfer is repeated in full.
- R7: Hold is acknowledged only between cycles, the clock after a single-transfer or burst cycle has completed. Acknowledge stays high with no address strobe while hold is requested and drops the clock after hold is sampled low.
- R8: For a code-fetch cycle (kind code 2), hold is acknowledged at the split point right after any of its ready transfers, before the next transfer is issued.
- R9: Kind code 0 is a single-transfer cycle of NB ready-ended transfers, spaced three clocks apart. Code 1 is a burst of BL burst-ready beats after one strobe. A request is accepted with one grant pulse, and the cycle ends with one done pulse BL+1 clocks (burst) or 3*(NB-1)+2 clocks (other kinds) after its first strobe.
- R10: While reset is applied, the strobe, acknowledge, float, grant and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| ahold_i | input | 1 | Address hold request |
| boff_i | input | 1 | Back-off request |
| hold_i | input | 1 | Bus hold request |
| rdy_i | input | 1 | Transfer ready for single-transfer and code-fetch cycles |
| brdy_i | input | 1 | Burst ready beat for bursts and write-backs |
| req_valid_i | input | 1 | Processor cycle request, held until granted |
| req_kind_i | input | 2 | Cycle kind: 0 single, 1 burst, 2 code fetch |
| req_addr_i | input | AW | Processor cycle address |
| swb_req_i | input | 1 | Snoop write-back request pulse |
| swb_addr_i | input | AW | Line address of the write-back |
| ads_o | output | 1 | Address strobe |
| ads_wb_o | output | 1 | Current strobe belongs to a snoop write-back |
| addr_o | output | AW | Address of the current cycle |
| hlda_o | output | 1 | Hold acknowledge |
| addr_float_o | output | 1 | Address bus float enable |
| grant_o | output | 1 | Processor request accepted |
| done_o | output | 1 | Processor cycle completed |

## Verification
Each of the three cycle kinds is crossed with five interference patterns: no interference, address-hold with one write-back, address-hold with two write-backs, back-off with one write-back, and hold. The order and addresses of the strobes separate the case where a write-back cuts into a split single or fetch cycle from the case where a burst finishes first. They also show whether a backed-off transfer is repeated or skipped, and whether queued write-backs keep their arrival order. The clock in which acknowledge appears separates the fetch exception from the between-cycles rule, and the done timing of the clean runs pins the beat and transfer counts of each kind.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [1:0] {
      CYC_SINGLE = 2'd0,
      CYC_BURST  = 2'd1,
      CYC_FETCH  = 2'd2
   } cyc_kind_e;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_ADDR,
      BUS_DATA,
      BUS_BACKOFF,
      BUS_GRANTED
   } bus_state_e;

endpackage

// File: rtl/snoop_wb_fifo.sv
module snoop_wb_fifo #(
   parameter int AW    = 16,
   parameter int DEPTH = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [AW-1:0] addr_i,
   input  logic          pop_i,
   output logic          empty_o,
   output logic [AW-1:0] head_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("snoop_wb_fifo: DEPTH must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("snoop_wb_fifo: AW must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic          valid_q;
      logic [AW-1:0] data_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            valid_q <= 1'b0;
            data_q  <= '0;
         end else begin
            if (pop_i) valid_q <= 1'b0;
            if (push_i && (!valid_q || pop_i)) begin
               valid_q <= 1'b1;
               data_q  <= addr_i;
            end
         end
      end

      assign empty_o = !valid_q;
      assign head_o  = data_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);

      logic [AW-1:0] mem_q [DEPTH];
      logic [PW-1:0] wr_q, rd_q;
      logic [CW-1:0] cnt_q;
      logic          full, do_push, do_pop;

      assign full    = (cnt_q == CW'(DEPTH));
      assign do_pop  = pop_i && (cnt_q != '0);
      assign do_push = push_i && (!full || do_pop);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
         end
      end

      always_ff @(posedge clk_i) begin
         if (do_push) mem_q[wr_q] <= addr_i;
      end

      assign empty_o = (cnt_q == '0);
      assign head_o  = mem_q[rd_q];
   end

   // R4: the sequencer retires a write-back only when one is queued
   assert_pop_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> !empty_o);

endmodule

// File: rtl/snoop_hold_gate.sv
module snoop_hold_gate
   import snp_pkg::*;
#(
   parameter bit EARLY_FETCH_GRANT = 1'b1
) (
   input  logic      cpu_busy_i,
   input  logic      cpu_started_i,
   input  cyc_kind_e kind_i,
   output logic      ok_o
);

   if (EARLY_FETCH_GRANT) begin : g_fetch_split
      // An uncached code fetch may yield the bus at any of its split points.
      assign ok_o = !(cpu_busy_i && cpu_started_i) || (kind_i == CYC_FETCH);
   end else begin : g_strict
      assign ok_o = !(cpu_busy_i && cpu_started_i);
   end

endmodule

// File: rtl/snoop_bus_seq.sv
module snoop_bus_seq
   import snp_pkg::*;
#(
   parameter int AW                = 16,
   parameter int BL                = 4,
   parameter int NB                = 2,
   parameter int WBQ_DEPTH         = 2,
   parameter bit EARLY_FETCH_GRANT = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ahold_i,
   input  logic          boff_i,
   input  logic          hold_i,
   input  logic          rdy_i,
   input  logic          brdy_i,
   input  logic          req_valid_i,
   input  logic [1:0]    req_kind_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic          swb_req_i,
   input  logic [AW-1:0] swb_addr_i,
   output logic          ads_o,
   output logic          ads_wb_o,
   output logic [AW-1:0] addr_o,
   output logic          hlda_o,
   output logic          addr_float_o,
   output logic          grant_o,
   output logic          done_o
);

   localparam int BW = $clog2(BL + 1);
   localparam int XW = $clog2(NB + 1);

   if (BL < 2) begin : g_bad_bl
      $error("snoop_bus_seq: BL must be at least 2");
   end
   if (NB < 1) begin : g_bad_nb
      $error("snoop_bus_seq: NB must be at least 1");
   end

   bus_state_e    state_q;
   logic          owner_wb_q;
   logic          cpu_busy_q;
   cyc_kind_e     cpu_kind_q;
   logic [AW-1:0] cpu_addr_q;
   logic [AW-1:0] bus_addr_q;
   logic [XW-1:0] xfer_left_q;
   logic [BW-1:0] beat_left_q;
   logic          grant_q, done_q;

   logic          q_empty;
   logic [AW-1:0] q_head;
   logic          wb_finish;
   logic          hold_ok;
   logic          cpu_started;
   logic          last_beat;

   assign last_beat   = (beat_left_q == BW'(1));
   assign cpu_started = (xfer_left_q != XW'(NB));
   assign wb_finish   = (state_q == BUS_DATA) && owner_wb_q && !boff_i && brdy_i && last_beat;

   snoop_wb_fifo #(
      .AW   (AW),
      .DEPTH(WBQ_DEPTH)
   ) u_wbq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (swb_req_i),
      .addr_i (swb_addr_i),
      .pop_i  (wb_finish),
      .empty_o(q_empty),
      .head_o (q_head)
   );

   snoop_hold_gate #(
      .EARLY_FETCH_GRANT(EARLY_FETCH_GRANT)
   ) u_hold (
      .cpu_busy_i   (cpu_busy_q),
      .cpu_started_i(cpu_started),
      .kind_i       (cpu_kind_q),
      .ok_o         (hold_ok)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= BUS_IDLE;
         owner_wb_q  <= 1'b0;
         cpu_busy_q  <= 1'b0;
         cpu_kind_q  <= CYC_SINGLE;
         cpu_addr_q  <= '0;
         bus_addr_q  <= '0;
         xfer_left_q <= '0;
         beat_left_q <= '0;
         grant_q     <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         grant_q <= 1'b0;
         done_q  <= 1'b0;
         if (boff_i && state_q != BUS_GRANTED) begin
            // Back-off stops the bus at once; a halted cycle restarts from its strobe.
            state_q <= BUS_BACKOFF;
         end else begin
            unique case (state_q)
               BUS_IDLE: begin
                  if (hold_i && hold_ok) begin
                     state_q <= BUS_GRANTED;
                  end else if (!q_empty) begin
                     state_q     <= BUS_ADDR;
                     owner_wb_q  <= 1'b1;
                     bus_addr_q  <= q_head;
                     beat_left_q <= BW'(BL);
                  end else if (!ahold_i) begin
                     if (cpu_busy_q) begin
                        state_q     <= BUS_ADDR;
                        owner_wb_q  <= 1'b0;
                        bus_addr_q  <= cpu_addr_q;
                        beat_left_q <= BW'(BL);
                     end else if (req_valid_i) begin
                        state_q     <= BUS_ADDR;
                        owner_wb_q  <= 1'b0;
                        grant_q     <= 1'b1;
                        cpu_busy_q  <= 1'b1;
                        cpu_kind_q  <= cyc_kind_e'(req_kind_i);
                        cpu_addr_q  <= req_addr_i;
                        bus_addr_q  <= req_addr_i;
                        xfer_left_q <= XW'(NB);
                        beat_left_q <= BW'(BL);
                     end
                  end
               end
               BUS_ADDR: state_q <= BUS_DATA;
               BUS_DATA: begin
                  if (owner_wb_q) begin
                     if (brdy_i) begin
                        if (last_beat) state_q <= BUS_IDLE;
                        else beat_left_q <= beat_left_q - 1'b1;
                     end
                  end else if (cpu_kind_q == CYC_BURST) begin
                     if (brdy_i) begin
                        if (last_beat) begin
                           state_q    <= BUS_IDLE;
                           cpu_busy_q <= 1'b0;
                           done_q     <= 1'b1;
                        end else begin
                           beat_left_q <= beat_left_q - 1'b1;
                        end
                     end
                  end else if (rdy_i) begin
                     // Each ready ends one transfer; the cycle may be split here.
                     state_q <= BUS_IDLE;
                     if (xfer_left_q == XW'(1)) begin
                        cpu_busy_q <= 1'b0;
                        done_q     <= 1'b1;
                     end else begin
                        xfer_left_q <= xfer_left_q - 1'b1;
                     end
                  end
               end
               BUS_BACKOFF: state_q <= BUS_IDLE;
               BUS_GRANTED: if (!hold_i) state_q <= BUS_IDLE;
               default:     state_q <= BUS_IDLE;
            endcase
         end
      end
   end

   assign ads_o        = (state_q == BUS_ADDR);
   assign ads_wb_o     = ads_o && owner_wb_q;
   assign addr_o       = bus_addr_q;
   assign hlda_o       = (state_q == BUS_GRANTED);
   assign addr_float_o = ahold_i || (state_q == BUS_BACKOFF) || (state_q == BUS_GRANTED);
   assign grant_o      = grant_q;
   assign done_o       = done_q;

   // R2: a strobe decided under address hold must belong to a write-back
   assert_ahold_wb_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ads_o && $past(ahold_i)) |-> ads_wb_o);

   // R5: back-off silences the strobe and floats the address one clock later
   assert_boff_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(boff_i) |-> (!ads_o && addr_float_o));

   // R7: acknowledge drops the clock after hold is withdrawn
   assert_hlda_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(hlda_o) && !$past(hold_i)) |-> !hlda_o);

   // R9: a grant pulse answers a pending request only
   assert_grant_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |-> $past(req_valid_i));

   // R7: no strobe may be driven while the bus is handed over
   assert_no_ads_hlda_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(hlda_o) && $past(hold_i)) |-> !ads_o);

endmodule

// File: tb/snoop_bus_seq_tb.sv
`timescale 1ns/1ps
module snoop_bus_seq_tb;

   localparam int AW = 12;
   localparam int BL = 4;
   localparam int NB = 2;
   localparam int QD = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ahold = 1'b0, boff = 1'b0, hold = 1'b0;
   logic          rdy = 1'b1, brdy = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic          swb_req = 1'b0;
   logic [AW-1:0] swb_addr = '0;
   logic          ads, ads_wb, hlda, flt, grant, done;
   logic [AW-1:0] addr;

   snoop_bus_seq #(
      .AW(AW), .BL(BL), .NB(NB), .WBQ_DEPTH(QD), .EARLY_FETCH_GRANT(1'b1)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ahold_i(ahold), .boff_i(boff), .hold_i(hold),
      .rdy_i(rdy), .brdy_i(brdy), .req_valid_i(req_valid), .req_kind_i(req_kind),
      .req_addr_i(req_addr), .swb_req_i(swb_req), .swb_addr_i(swb_addr),
      .ads_o(ads), .ads_wb_o(ads_wb), .addr_o(addr), .hlda_o(hlda),
      .addr_float_o(flt), .grant_o(grant), .done_o(done)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int ads_n, grant_n, done_n, done_cyc, hlda_cyc, overlap;
   logic          hlda_flt;
   logic [AW-1:0] lg_addr [32];
   logic          lg_wb   [32];
   int            lg_cyc  [32];

   task automatic tick();
      @(negedge clk);
      cyc++;
      if (ads) begin
         if (ads_n < 32) begin
            lg_addr[ads_n] = addr;
            lg_wb[ads_n]   = ads_wb;
            lg_cyc[ads_n]  = cyc;
         end
         ads_n++;
      end
      if (hlda && hlda_cyc < 0) begin
         hlda_cyc = cyc;
         hlda_flt = flt;
      end
      if (hlda && ads) overlap++;
      if (grant) grant_n++;
      if (done) begin
         done_n++;
         done_cyc = cyc;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // mech: 0 none, 1 address hold + one write-back, 2 address hold + two,
   //       3 back-off + one write-back, 4 hold
   task automatic run(input int ty, input int mech);
      logic [AW-1:0] a, w;
      logic [AW-1:0] ea [8];
      logic          ew [8];
      int en, rest, n0, drop_cyc, guard;
      bit ok;
      string tag;
      a = AW'(12'h100 + ty * 16 + mech);
      w = AW'(12'h800 + ty * 16 + mech * 2);
      rest = (ty == 1) ? 1 : NB;
      en = 0;
      ea[en] = a; ew[en] = 1'b0; en++;
      if (mech == 1 || mech == 2 || mech == 3) begin
         ea[en] = w; ew[en] = 1'b1; en++;
      end
      if (mech == 2) begin
         ea[en] = w + 1'b1; ew[en] = 1'b1; en++;
      end
      for (int k = 0; k < ((mech == 3) ? rest : rest - 1); k++) begin
         ea[en] = a; ew[en] = 1'b0; en++;
      end

      ads_n = 0; grant_n = 0; done_n = 0; done_cyc = -1; hlda_cyc = -1;
      overlap = 0; hlda_flt = 1'b0; drop_cyc = 0;
      req_valid = 1'b1; req_kind = 2'(ty); req_addr = a;
      guard = 0;
      do begin
         tick();
         guard++;
      end while (grant_n == 0 && guard < 10);
      n0 = cyc;
      req_valid = 1'b0;
      if (mech == 1 || mech == 2) ahold = 1'b1;
      if (mech == 3) boff = 1'b1;
      if (mech == 4) hold = 1'b1;
      if (mech >= 1 && mech <= 3) begin
         swb_req = 1'b1; swb_addr = w;
      end
      tick();
      if (mech == 1 || mech == 2)
         check(flt == 1'b1, "R1 float under address hold", int'(flt), 1);
      if (mech == 3) begin
         check(flt == 1'b1, "R1 float under back-off", int'(flt), 1);
         check(ads == 1'b0, "R5 strobe after back-off", int'(ads), 0);
      end
      if (mech == 2) begin
         swb_req = 1'b1; swb_addr = w + 1'b1;
      end else begin
         swb_req = 1'b0;
      end
      tick();
      swb_req = 1'b0;
      for (int t = 3; t <= 60; t++) begin
         tick();
         if (t == 5 && mech == 3) boff = 1'b0;
         if (t == 14 && mech == 4) begin
            check(hlda == 1'b1, "R7 acknowledge while hold", int'(hlda), 1);
            hold = 1'b0;
         end
         if (t == 15 && mech == 4)
            check(hlda == 1'b0, "R7 acknowledge release", int'(hlda), 0);
         if (t == 20 && (mech == 1 || mech == 2)) begin
            ahold = 1'b0;
            drop_cyc = cyc;
         end
      end

      ok = (ads_n == en);
      if (ok) begin
         for (int k = 0; k < en; k++)
            if (lg_addr[k] != ea[k] || lg_wb[k] != ew[k]) ok = 1'b0;
      end
      case (mech)
         0: tag = "R9 strobe sequence";
         1: tag = (ty == 1) ? "R3 burst then write-back" : "R4 split order";
         2: tag = "R4 two write-backs in order";
         3: tag = "R6 restart order";
         default: tag = (ty == 2) ? "R8 fetch sequence" : "R7 hold sequence";
      endcase
      $display("  kind %0d pattern %0d: %0d strobes", ty, mech, ads_n);
      check(ok, tag, ads_n, en);
      check(grant_n == 1 && done_n == 1, "R9 grant and done once",
            grant_n * 10 + done_n, 11);
      if (mech == 0)
         check(done_cyc - lg_cyc[0] == ((ty == 1) ? BL + 1 : 3 * (NB - 1) + 2),
               "R9 completion timing", done_cyc - lg_cyc[0],
               (ty == 1) ? BL + 1 : 3 * (NB - 1) + 2);
      if ((mech == 1 || mech == 2) && ok) begin
         if (ty == 1)
            check(lg_cyc[1] - lg_cyc[0] == BL + 2, "R3 burst runs all beats",
                  lg_cyc[1] - lg_cyc[0], BL + 2);
         else
            check(lg_cyc[en - 1] > drop_cyc, "R2 resume only after address hold",
                  lg_cyc[en - 1], drop_cyc + 1);
      end
      if (mech == 3 && ok)
         check(lg_cyc[1] > n0 + 5, "R6 nothing before back-off release",
               lg_cyc[1], n0 + 6);
      if (mech == 4) begin
         check(hlda_cyc > 0 && hlda_flt, "R1 float during acknowledge",
               int'(hlda_flt), 1);
         check(overlap == 0, "R7 no strobe during acknowledge", overlap, 0);
         if (ty == 2 && ads_n >= 2)
            check(hlda_cyc > lg_cyc[0] && hlda_cyc < lg_cyc[1],
                  "R8 fetch yields at split", hlda_cyc, lg_cyc[0] + 3);
         else if (ty != 2)
            check(hlda_cyc == done_cyc + 1, "R7 acknowledge between cycles",
                  hlda_cyc, done_cyc + 1);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) tick();
      check(!ads && !hlda && !flt && !grant && !done, "R10 reset outputs",
            int'({ads, hlda, flt, grant, done}), 0);
      rst_n = 1'b1;
      repeat (2) tick();
      for (int ty = 0; ty < 3; ty++)
         for (int m = 0; m < 5; m++)
            run(ty, m);
      summary();
      $finish;
   end

   initial begin
      #1000000ns;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

endmodule